// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit executes register-to-register shift and rotate instructions. It gets a 16-bit instruction word with a valid strobe. It also sees all eight 32-bit data registers as one flat vector, plus the current extend flag. The unit decodes the word and chooses the shift count. The count comes either from a 3-bit immediate field or from the low bits of a data register. The unit then applies one of four operations to a byte, word or long operand taken from the destination register: arithmetic shift, logical shift, plain rotate, or rotate through the extend bit. Each operation can run left or right.

One clock edge after a recognised strobe, the unit presents three things. It gives a write-back request for the destination register, with the untouched upper lanes merged back in. It gives the new condition flags. Or, in place of both, it raises an illegal-instruction pulse. The surrounding pipeline owns the register file and the flag register, and commits the request when it sees it.

Top module: `shift_rotate_unit`

## Requirements
- R1: A word is acted on only when `valid_i` is high and bits 15..12 equal 1110. Any other word gives `wr_en_o` = 0 and `illegal_o` = 0 on the next cycle.
- R2: The size field is bits 7..6: 00 byte, 01 word, 10 long. A recognised word with size 11 raises `illegal_o` for one cycle on the next edge, with `wr_en_o` = 0.
- R3: Bit 5 selects the count source. With bit 5 = 0, the count is bits 11..9 (value 1..7), and 000 means 8. With bit 5 = 1, the count is the low 6 bits of the data register numbered by bits 11..9. Bits 2..0 name the destination, which is also the source operand.
- R4: A count of zero leaves the operand unchanged. It also gives C = 0, V = 0 and X equal to `x_i`, whatever the operation.
- R5: Logical shifts (bits 4..3 = 01) fill with zeros. C and X take the last bit shifted out, and V = 0. A count above the operand width gives a zero result with C = X = 0. Bit 8 = 1 means left and 0 means right, for every operation.
- R6: Arithmetic right shift (bits 4..3 = 00, bit 8 = 0) fills with the sign bit. C and X take the last bit out, and a count at or above the width leaves every bit equal to the sign.
- R7: Arithmetic left shift gives the same result, C and X as a logical left shift. V is 1 when the sign bit took more than one value during the shift.
- R8: Plain rotate (bits 4..3 = 11) turns the operand by count modulo width. C is the last bit carried around, X keeps `x_i`, and V = 0.
- R9: Rotate through extend (bits 4..3 = 10) turns the width+1 bit value {X, operand} by count modulo width+1. C and X both take the new extend bit, and V = 0.
- R10: Byte and word operations keep destination bits above the operand size. `wr_data_o` carries the full 32-bit register value and `wr_idx_o` names the destination.
- R11: `flags_o` is {X, N, Z, V, C} in bits 4..0. N is the top bit of the sized result. Z is 1 when the sized result is zero.
- R12: After reset, every output is zero. Results appear on the edge after the strobe, and `wr_en_o` and `illegal_o` are high for exactly one cycle per accepted strobe and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 16 | Instruction word |
| regs_i | input | 256 | Data registers, register k in bits 32k+31..32k |
| x_i | input | 1 | Current extend flag |
| wr_en_o | output | 1 | Write-back and flag update request |
| illegal_o | output | 1 | Illegal size pulse |
| wr_idx_o | output | 3 | Destination register number |
| wr_data_o | output | 32 | Merged destination value |
| flags_o | output | 5 | {X, N, Z, V, C} |

## Verification
The bench targets the following corner cases. For each, it names the failure that a wrong design would show:
- An immediate field of 000: a design that ignores this takes it as a count of zero and returns the operand unchanged.
- Register counts beyond the width: a wrapping shifter gives a nonzero logical result, or drops the sign fill of an arithmetic shift.
- Rotate-through-extend counts equal to width+1: these must return the original value with X as carry. A width-modulo design rotates by the wrong amount.
- Arithmetic left shifts whose sign bit toggles only deep into the count: a design that compares only the first and last sign loses the overflow.
- Zero counts: a design that forgets the special case either moves the extend flag or leaves a stale carry.
- Byte and word writes: these catch a merge that clobbers the upper bits.
- Size 11 and foreign opcodes: these catch spurious write requests.

// File: rtl/sr_pkg.sv
package sr_pkg;

   localparam logic [3:0] SR_OPCODE = 4'b1110;

   typedef enum logic [1:0] {
      OP_ASH = 2'b00,
      OP_LSH = 2'b01,
      OP_RXT = 2'b10,
      OP_ROT = 2'b11
   } sr_op_e;

   typedef enum logic [1:0] {
      SZ_B   = 2'b00,
      SZ_W   = 2'b01,
      SZ_L   = 2'b10,
      SZ_BAD = 2'b11
   } sr_size_e;

   typedef struct packed {
      logic       hit;
      logic       legal;
      logic [2:0] cnt_field;
      logic       left;
      sr_size_e   size;
      logic       from_reg;
      sr_op_e     op;
      logic [2:0] dst;
   } sr_dec_t;

endpackage

// File: rtl/sr_decode.sv
module sr_decode
   import sr_pkg::*;
(
   input  logic        valid_i,
   input  logic [15:0] instr_i,
   output sr_dec_t     dec_o
);
   always_comb begin
      dec_o.hit       = valid_i && (instr_i[15:12] == SR_OPCODE);
      dec_o.cnt_field = instr_i[11:9];
      dec_o.left      = instr_i[8];
      dec_o.size      = sr_size_e'(instr_i[7:6]);
      dec_o.from_reg  = instr_i[5];
      dec_o.op        = sr_op_e'(instr_i[4:3]);
      dec_o.dst       = instr_i[2:0];
      dec_o.legal     = (instr_i[7:6] != SZ_BAD);
   end
endmodule

// File: rtl/sr_count.sv
module sr_count #(
   parameter int CNT_W = 6,
   parameter int IMM_W = 3
) (
   input  logic             from_reg_i,
   input  logic [IMM_W-1:0] field_i,
   input  logic [CNT_W-1:0] reg_cnt_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int IMM_ZERO_MEANS = 1 << IMM_W;

   if (CNT_W <= IMM_W) begin : g_bad_cnt
      $error("sr_count: CNT_W must exceed IMM_W");
   end

   logic [CNT_W-1:0] imm_cnt;
   assign imm_cnt = (field_i == '0) ? CNT_W'(IMM_ZERO_MEANS) : CNT_W'(field_i);
   assign cnt_o   = from_reg_i ? reg_cnt_i : imm_cnt;
endmodule

// File: rtl/sr_lane.sv
module sr_lane
   import sr_pkg::*;
#(
   parameter int W     = 8,
   parameter int CNT_W = 6
) (
   input  logic [W-1:0]     d_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  sr_op_e           op_i,
   input  logic             left_i,
   input  logic             x_i,
   output logic [W-1:0]     res_o,
   output logic             c_o,
   output logic             x_o,
   output logic             v_o
);
   if (W < 2) begin : g_bad_w
      $error("sr_lane: W must be at least 2");
   end
   if (W + 1 >= (1 << CNT_W)) begin : g_bad_mod
      $error("sr_lane: CNT_W too narrow for W+1 rotation");
   end

   // shifts through a double-width window
   logic [2*W-1:0] lsl_t, lsr_t, asr_t;
   assign lsl_t = {{W{1'b0}}, d_i} << cnt_i;
   assign lsr_t = {d_i, {W{1'b0}}} >> cnt_i;
   assign asr_t = $signed({d_i, {W{1'b0}}}) >>> cnt_i;

   // sign history for arithmetic left shift
   logic [W-1:0] asl_r, asl_back;
   logic         asl_v;
   assign asl_r    = d_i << cnt_i;
   assign asl_back = $signed(asl_r) >>> cnt_i;
   assign asl_v    = (asl_back != d_i);

   // plain rotate modulo W
   logic [CNT_W-1:0] k_ro;
   logic [2*W-1:0]   rol_t, ror_t;
   assign k_ro  = CNT_W'(32'(cnt_i) % W);
   assign rol_t = {d_i, d_i} << k_ro;
   assign ror_t = {d_i, d_i} >> k_ro;

   // rotate through extend modulo W+1
   logic [CNT_W-1:0] k_rx;
   logic [W:0]       xv;
   logic [2*W+1:0]   rxl_t, rxr_t;
   assign k_rx  = CNT_W'(32'(cnt_i) % (W + 1));
   assign xv    = {x_i, d_i};
   assign rxl_t = {xv, xv} << k_rx;
   assign rxr_t = {xv, xv} >> k_rx;

   always_comb begin
      res_o = d_i;
      c_o   = 1'b0;
      x_o   = x_i;
      v_o   = 1'b0;
      if (cnt_i != '0) begin
         unique case (op_i)
            OP_ASH, OP_LSH: begin
               if (left_i) begin
                  res_o = lsl_t[W-1:0];
                  c_o   = lsl_t[W];
                  v_o   = (op_i == OP_ASH) ? asl_v : 1'b0;
               end else if (op_i == OP_ASH) begin
                  res_o = asr_t[2*W-1:W];
                  c_o   = asr_t[W-1];
               end else begin
                  res_o = lsr_t[2*W-1:W];
                  c_o   = lsr_t[W-1];
               end
               x_o = c_o;
            end
            OP_ROT: begin
               if (left_i) begin
                  res_o = rol_t[2*W-1:W];
                  c_o   = res_o[0];
               end else begin
                  res_o = ror_t[W-1:0];
                  c_o   = res_o[W-1];
               end
            end
            OP_RXT: begin
               if (left_i) begin
                  res_o = rxl_t[2*W:W+1];
                  x_o   = rxl_t[2*W+1];
               end else begin
                  res_o = rxr_t[W-1:0];
                  x_o   = rxr_t[W];
               end
               c_o = x_o;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
   import sr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NREG   = 8,
   parameter int CNT_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     valid_i,
   input  logic [15:0]              instr_i,
   input  logic [NREG*DATA_W-1:0]   regs_i,
   input  logic                     x_i,
   output logic                     wr_en_o,
   output logic                     illegal_o,
   output logic [2:0]               wr_idx_o,
   output logic [DATA_W-1:0]        wr_data_o,
   output logic [4:0]               flags_o
);
   localparam int IMM_W  = 3;
   localparam int NLANES = 3;

   if (NREG != (1 << IMM_W)) begin : g_bad_nreg
      $error("shift_rotate_unit: NREG must match the 3-bit register fields");
   end
   if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_dw
      $error("shift_rotate_unit: DATA_W must be a multiple of 4, at least 8");
   end

   sr_dec_t dec;
   sr_decode u_dec (.valid_i(valid_i), .instr_i(instr_i), .dec_o(dec));

   logic [DATA_W-1:0] src;
   logic [DATA_W-1:0] cnt_reg;
   logic [CNT_W-1:0]  cnt;
   assign src     = regs_i[32'(dec.dst) * DATA_W +: DATA_W];
   assign cnt_reg = regs_i[32'(dec.cnt_field) * DATA_W +: DATA_W];

   sr_count #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_cnt (
      .from_reg_i(dec.from_reg),
      .field_i   (dec.cnt_field),
      .reg_cnt_i (cnt_reg[CNT_W-1:0]),
      .cnt_o     (cnt)
   );

   logic [DATA_W-1:0] lane_res  [NLANES];
   logic [DATA_W-1:0] lane_mask [NLANES];
   logic [NLANES-1:0] lane_c, lane_x, lane_v, lane_n, lane_z;

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      localparam int W = DATA_W >> (NLANES - 1 - i);
      logic [W-1:0] res;
      sr_lane #(.W(W), .CNT_W(CNT_W)) u_lane (
         .d_i   (src[W-1:0]),
         .cnt_i (cnt),
         .op_i  (dec.op),
         .left_i(dec.left),
         .x_i   (x_i),
         .res_o (res),
         .c_o   (lane_c[i]),
         .x_o   (lane_x[i]),
         .v_o   (lane_v[i])
      );
      assign lane_res[i]  = DATA_W'(res);
      assign lane_mask[i] = DATA_W'({W{1'b1}});
      assign lane_n[i]    = res[W-1];
      assign lane_z[i]    = (res == '0);
   end

   logic [DATA_W-1:0] sel_res, sel_mask, merged;
   logic [4:0]        sel_flags;
   always_comb begin
      unique case (dec.size)
         SZ_B: begin
            sel_res   = lane_res[0];
            sel_mask  = lane_mask[0];
            sel_flags = {lane_x[0], lane_n[0], lane_z[0], lane_v[0], lane_c[0]};
         end
         SZ_W: begin
            sel_res   = lane_res[1];
            sel_mask  = lane_mask[1];
            sel_flags = {lane_x[1], lane_n[1], lane_z[1], lane_v[1], lane_c[1]};
         end
         default: begin
            sel_res   = lane_res[2];
            sel_mask  = lane_mask[2];
            sel_flags = {lane_x[2], lane_n[2], lane_z[2], lane_v[2], lane_c[2]};
         end
      endcase
      merged = (src & ~sel_mask) | sel_res;
   end

   logic accept;
   assign accept = dec.hit && dec.legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o   <= 1'b0;
         illegal_o <= 1'b0;
         wr_idx_o  <= '0;
         wr_data_o <= '0;
         flags_o   <= '0;
      end else begin
         wr_en_o   <= accept;
         illegal_o <= dec.hit && !dec.legal;
         if (accept) begin
            wr_idx_o  <= dec.dst;
            wr_data_o <= merged;
            flags_o   <= sel_flags;
         end
      end
   end

   // foreign opcodes never produce any request
   assert_ignore_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && instr_i[15:12] != SR_OPCODE) |=> (!wr_en_o && !illegal_o));

   // size code 11 only raises the illegal pulse
   assert_bad_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && instr_i[15:12] == SR_OPCODE && instr_i[7:6] == 2'b11)
      |=> (illegal_o && !wr_en_o));

   // zero count keeps operand, clears carry, keeps extend
   assert_count_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cnt == '0) |=> (wr_data_o == $past(src) && !flags_o[0]
                                 && !flags_o[1] && flags_o[4] == $past(x_i)));

   // plain rotate leaves extend alone
   assert_rot_keeps_x_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec.op == OP_ROT) |=> (flags_o[4] == $past(x_i)));

   // byte operations keep the upper bits of the register
   assert_lane_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec.size == SZ_B) |=> (wr_data_o[DATA_W-1:8] == $past(src[DATA_W-1:8])));

   // request and illegal are exclusive
   assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_o && illegal_o));
endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_i = 1'b0;
   logic [15:0]  instr_i = '0;
   logic [255:0] regs_i;
   logic         x_i = 1'b0;
   logic         wr_en_o, illegal_o;
   logic [2:0]   wr_idx_o;
   logic [31:0]  wr_data_o;
   logic [4:0]   flags_o;

   logic [31:0] rf [8];
   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   always_comb
      for (int k = 0; k < 8; k++) regs_i[k*32 +: 32] = rf[k];

   shift_rotate_unit dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
      .regs_i(regs_i), .x_i(x_i), .wr_en_o(wr_en_o), .illegal_o(illegal_o),
      .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .flags_o(flags_o)
   );

   // expected values from a bit-at-a-time model
   logic        e_wr, e_ill;
   logic [31:0] e_data;
   logic [4:0]  e_flags;

   task automatic model(input logic [15:0] w, input logic xin);
      int n, cnt;
      logic [31:0] mask, d, src;
      logic x, c, v, o, sgn;
      e_wr = 1'b0; e_ill = 1'b0; e_data = '0; e_flags = '0;
      if (w[15:12] != 4'b1110) return;
      if (w[7:6] == 2'b11) begin e_ill = 1'b1; return; end
      e_wr = 1'b1;
      n    = (w[7:6] == 2'b00) ? 8 : (w[7:6] == 2'b01) ? 16 : 32;
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
      src  = rf[w[2:0]];
      d    = src & mask;
      cnt  = w[5] ? int'(rf[w[11:9]][5:0]) : ((w[11:9] == 3'd0) ? 8 : int'(w[11:9]));
      x = xin; c = 1'b0; v = 1'b0;
      for (int i = 0; i < cnt; i++) begin
         sgn = d[n-1];
         if (w[8]) begin
            o = d[n-1];
            case (w[4:3])
               2'b10:   d = ((d << 1) | 32'(x)) & mask;
               2'b11:   d = ((d << 1) | 32'(o)) & mask;
               default: d = (d << 1) & mask;
            endcase
            if (w[4:3] == 2'b00 && d[n-1] != sgn) v = 1'b1;
         end else begin
            o = d[0];
            case (w[4:3])
               2'b00:   d = (d >> 1) | (32'(sgn) << (n-1));
               2'b10:   d = (d >> 1) | (32'(x) << (n-1));
               2'b11:   d = (d >> 1) | (32'(o) << (n-1));
               default: d = d >> 1;
            endcase
         end
         c = o;
         if (w[4:3] != 2'b11) x = o;
      end
      e_data  = (src & ~mask) | d;
      e_flags = {x, d[n-1], (d == 0), v, c};
   endtask

   function automatic string tag_of(input logic [15:0] w);
      int cnt;
      if (w[15:12] != 4'b1110) return "R1";
      if (w[7:6] == 2'b11) return "R2";
      cnt = w[5] ? int'(rf[w[11:9]][5:0]) : 1;
      if (cnt == 0) return "R4";
      case (w[4:3])
         2'b00:   return w[8] ? "R7" : "R6";
         2'b01:   return "R5";
         2'b11:   return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check_out(input string tag, input logic [15:0] w);
      checks++;
      if (wr_en_o !== e_wr || illegal_o !== e_ill) begin
         fails++;
         $display("FAIL %s: instr %h wr/ill got %b%b exp %b%b", tag, w,
                  wr_en_o, illegal_o, e_wr, e_ill);
      end else if (e_wr && (wr_data_o !== e_data || flags_o !== e_flags
                            || wr_idx_o !== w[2:0])) begin
         fails++;
         $display("FAIL %s: instr %h data/flags/idx got %h/%b/%0d exp %h/%b/%0d",
                  tag, w, wr_data_o, flags_o, wr_idx_o, e_data, e_flags, w[2:0]);
      end
   endtask

   task automatic run(input logic [15:0] w, input logic xin, input string tag);
      valid_i = 1'b1; instr_i = w; x_i = xin;
      model(w, xin);
      @(negedge clk);
      check_out(tag, w);
   endtask

   function automatic logic [15:0] mk(input logic [2:0] cf, input logic left,
                                      input logic [1:0] sz, input logic fr,
                                      input logic [1:0] op, input logic [2:0] dst);
      return {4'b1110, cf, left, sz, fr, op, dst};
   endfunction

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] w;
      void'($urandom(32'd20240611));
      for (int k = 0; k < 8; k++) rf[k] = 32'h0;
      repeat (3) @(negedge clk);
      checks++;
      if (wr_en_o !== 1'b0 || illegal_o !== 1'b0 || wr_data_o !== '0 || flags_o !== '0) begin
         fails++;
         $display("FAIL R12: reset outputs got %b%b %h %b exp 00 0 0",
                  wr_en_o, illegal_o, wr_data_o, flags_o);
      end
      rst_n = 1'b1;
      @(negedge clk);

      rf[0] = 32'h1234_5681; rf[1] = 32'h8000_0001; rf[2] = 32'd40;
      rf[3] = 32'h0000_0000; rf[4] = 32'hAAAA_55C3; rf[5] = 32'd9;
      rf[6] = 32'hFFFF_8001; rf[7] = 32'h0000_0040;

      run(16'h7123, 1'b0, "R1");                              // foreign opcode
      run(mk(3'd1, 1'b1, 2'b11, 1'b0, 2'b01, 3'd0), 1'b0, "R2");
      run(mk(3'd0, 1'b0, 2'b10, 1'b0, 2'b01, 3'd0), 1'b0, "R3"); // imm 000 = 8
      run(mk(3'd2, 1'b0, 2'b10, 1'b1, 2'b01, 3'd4), 1'b1, "R3"); // reg count 40
      run(mk(3'd7, 1'b1, 2'b10, 1'b1, 2'b01, 3'd0), 1'b1, "R4"); // low 6 bits 0
      run(mk(3'd2, 1'b1, 2'b00, 1'b1, 2'b01, 3'd4), 1'b0, "R5"); // byte lsl 40
      run(mk(3'd2, 1'b0, 2'b10, 1'b1, 2'b00, 3'd1), 1'b0, "R6"); // asr past width
      run(mk(3'd3, 1'b0, 2'b01, 1'b0, 2'b00, 3'd6), 1'b0, "R6");
      run(mk(3'd3, 1'b1, 2'b00, 1'b0, 2'b00, 3'd4), 1'b0, "R7"); // asl overflow
      run(mk(3'd1, 1'b1, 2'b10, 1'b0, 2'b00, 3'd3), 1'b0, "R7"); // zero, no V
      run(mk(3'd0, 1'b1, 2'b00, 1'b0, 2'b11, 3'd4), 1'b1, "R8"); // rol 8 on byte
      run(mk(3'd5, 1'b0, 2'b01, 1'b0, 2'b11, 3'd6), 1'b0, "R8");
      run(mk(3'd5, 1'b1, 2'b00, 1'b1, 2'b10, 3'd4), 1'b1, "R9"); // roxl 9 on byte
      run(mk(3'd3, 1'b0, 2'b01, 1'b0, 2'b10, 3'd6), 1'b1, "R9");
      run(mk(3'd2, 1'b1, 2'b01, 1'b0, 2'b01, 3'd6), 1'b0, "R10");
      run(mk(3'd4, 1'b0, 2'b00, 1'b0, 2'b01, 3'd1), 1'b0, "R11");
      valid_i = 1'b0;
      model(16'h0000, 1'b0);
      @(negedge clk);
      check_out("R12", 16'h0000);                              // pulse ends

      for (int t = 0; t < 600; t++) begin
         for (int k = 0; k < 8; k++) begin
            rf[k] = $urandom();
            if (($urandom() % 4) == 0) rf[k] = rf[k] & 32'h0000_003F;
         end
         w = 16'($urandom());
         if (($urandom() % 8) != 0) w[15:12] = 4'b1110;
         run(w, 1'($urandom()), tag_of(w));
      end

      valid_i = 1'b0;
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule